// File: doc/BRIEF.md
# Segment Selector Translation Unit

This block turns a segment-relative address into a flat linear address. It keeps a small file of segment slots. Each slot caches a copy of a segment descriptor: its 32-bit base, its expanded byte limit, its access type and its operand-size flag. A separate load port fills a slot. It takes a 16-bit selector and the current privilege level, computes where the 8-byte descriptor sits in the global or the local descriptor table, and checks that the entry lies inside that table. It then fetches the descriptor over a request/valid read port, validates it, and either writes the slot or reports a numbered fault.

The access port takes a slot number, a 32-bit offset and a read/write flag. One cycle later it returns the cached base plus the offset. In the same cycle it flags a fault when the slot is empty, when the offset lies beyond the expanded limit, or when the access type is not allowed. The table registers (global base/limit, local base/limit) are plain inputs that the surrounding logic loads. The unit captures them when it accepts a load.

The loader is a five-state machine. IDLE accepts a load request and moves to BOUND. BOUND compares the last byte of the descriptor with the table limit. It moves to DONE with a bound fault, or to FETCH. FETCH holds the read request until the read data is valid, then moves to VERIFY. VERIFY decodes the descriptor and writes the slot if every check passes. It always moves to DONE. DONE pulses the completion outputs for one cycle and returns to IDLE.

Top module: `seg_xlate`

## Requirements
- R1: Selector bits 1..0 are the requested privilege, bit 2 picks the table (0 global, 1 local) and bits 15..3 are the index. The descriptor read address is the chosen table base plus index*8, and it is held on dr_addr with dr_req high until dr_valid is seen.
- R2: If index*8+7 is greater than the chosen table limit, the load completes with ld_fcode=1 and no descriptor read is issued.
- R3: The slot base is assembled as {desc[63:56], desc[39:32], desc[31:16]}, and the 20-bit raw limit as {desc[51:48], desc[15:0]}.
- R4: When desc[55] is 1 the byte limit is (raw<<12)|0xFFF; when 0 it is the raw limit.
- R5: A descriptor with desc[44]=0 (a system segment) is refused with ld_fcode=2.
- R6: A descriptor with desc[47]=0 (not present) is refused with ld_fcode=3.
- R7: If the larger of ld_cpl and the requested privilege is numerically above desc[46:45], the load is refused with ld_fcode=4.
- R8: Fault priority is bound, then system, then not-present, then privilege. On a successful load ld_fcode=0 and ld_fault=0. A refused load leaves the slot's previous contents in place.
- R9: For an access presented in cycle n, ac_rsp_valid is high in cycle n+1 with ac_lin equal to the slot base plus ac_off (modulo 2^32).
- R10: An offset equal to the byte limit is accepted, and an offset one above it faults.
- R11: desc[43] set marks code, clear marks data, and desc[41] is write-enable for data and read-enable for code. A write to code, a write to data with desc[41]=0, and a read of code with desc[41]=0 fault. Other reads and writes do not.
- R12: An access to a slot that has not been loaded successfully since reset faults.
- R13: After reset, ld_busy, ld_done, dr_req and ac_rsp_valid are low. ld_done is a one-cycle pulse. ld_valid is ignored while ld_busy is high.
- R14: ac_def32 returns desc[54] of the slot used by the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ld_valid | input | 1 | Load request |
| ld_seg | input | SEG_W | Slot to load |
| ld_sel | input | 16 | Selector |
| ld_cpl | input | 2 | Current privilege level |
| ld_busy | output | 1 | Loader not idle |
| ld_done | output | 1 | Load finished (one cycle) |
| ld_fault | output | 1 | Load refused |
| ld_fcode | output | 3 | 0 none, 1 bound, 2 system, 3 absent, 4 privilege |
| gdt_base | input | 32 | Global table base |
| gdt_limit | input | 32 | Global table byte limit |
| ldt_base | input | 32 | Local table base |
| ldt_limit | input | 32 | Local table byte limit |
| dr_req | output | 1 | Descriptor read request |
| dr_addr | output | 32 | Descriptor address |
| dr_valid | input | 1 | Descriptor data valid |
| dr_data | input | 64 | Descriptor data |
| ac_valid | input | 1 | Access request |
| ac_seg | input | SEG_W | Slot used by the access |
| ac_off | input | 32 | Offset |
| ac_write | input | 1 | 1 = write, 0 = read |
| ac_rsp_valid | output | 1 | Access response |
| ac_lin | output | 32 | Linear address |
| ac_fault | output | 1 | Access refused |
| ac_def32 | output | 1 | 32-bit default operand size |

## Verification
The bench probes the limit at both edges of each granularity setting: offset equal to the byte limit and one above it. A design that forgets the 0xFFF fill-in or uses >= would fault on a legal last byte. It places a table entry so that its last byte sits exactly on the table limit and then one entry beyond. A design that checks only the first byte would fetch a descriptor that lies past the table end, and that shows up as an extra read. Descriptors with several defects at once check the fault priority. Refused loads, and loads attempted while busy, are each followed by accesses that show the slot has kept its old contents. A design that writes the slot on failure or restarts mid-load would return a different base or report a spurious fault.

// File: rtl/seg_pkg.sv
package seg_pkg;
    localparam int ADDR_W = 32;
    localparam int SEL_W  = 16;
    localparam int DESC_W = 64;
    localparam int RLIM_W = 20;

    typedef enum logic [2:0] {
        LF_NONE   = 3'd0,
        LF_BOUND  = 3'd1,
        LF_SYSTEM = 3'd2,
        LF_ABSENT = 3'd3,
        LF_PRIV   = 3'd4
    } ld_fault_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_BOUND,
        S_FETCH,
        S_VERIFY,
        S_DONE
    } ld_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] lim;
        logic              present;
        logic [1:0]        dpl;
        logic              usr;
        logic [3:0]        typ;
        logic              def32;
    } seg_attr_t;
endpackage

// File: rtl/seg_desc_decode.sv
module seg_desc_decode
    import seg_pkg::*;
(
    input  logic [DESC_W-1:0] desc,
    output seg_attr_t         attr
);
    logic [RLIM_W-1:0] raw_lim;
    logic              gran;

    always_comb begin
        raw_lim      = {desc[51:48], desc[15:0]};
        gran         = desc[55];
        attr.base    = {desc[63:56], desc[39:32], desc[31:16]};
        attr.lim     = gran ? {raw_lim, 12'hFFF}
                            : {{(ADDR_W-RLIM_W){1'b0}}, raw_lim};
        attr.present = desc[47];
        attr.dpl     = desc[46:45];
        attr.usr     = desc[44];
        attr.typ     = desc[43:40];
        attr.def32   = desc[54];
    end
endmodule

// File: rtl/seg_load_fsm.sv
module seg_load_fsm
    import seg_pkg::*;
#(
    parameter int NSEG  = 6,
    parameter int SEG_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [SEG_W-1:0]  ld_seg,
    input  logic [SEL_W-1:0]  ld_sel,
    input  logic [1:0]        ld_cpl,
    input  logic [ADDR_W-1:0] gdt_base,
    input  logic [ADDR_W-1:0] gdt_limit,
    input  logic [ADDR_W-1:0] ldt_base,
    input  logic [ADDR_W-1:0] ldt_limit,
    input  logic              dr_valid,
    input  logic [DESC_W-1:0] dr_data,
    output logic              ld_busy,
    output logic              ld_done,
    output logic              ld_fault,
    output logic [2:0]        ld_fcode,
    output logic              dr_req,
    output logic [ADDR_W-1:0] dr_addr,
    output logic              wr_en,
    output logic [SEG_W-1:0]  wr_idx,
    output seg_attr_t         wr_attr
);
    localparam int IDX_W = SEL_W - 3;

    ld_state_e         state, nxt;
    logic [SEG_W-1:0]  seg_q;
    logic [SEL_W-1:0]  sel_q;
    logic [1:0]        cpl_q;
    logic [ADDR_W-1:0] tbase_q, tlim_q;
    logic [DESC_W-1:0] desc_q;
    ld_fault_e         fcode_q, vcode;
    logic [ADDR_W-1:0] last_byte, ent_off;
    logic [1:0]        eff_pl;
    seg_attr_t         dec;

    seg_desc_decode u_dec (.desc(desc_q), .attr(dec));

    always_comb begin
        ent_off   = {{(ADDR_W-IDX_W-3){1'b0}}, sel_q[SEL_W-1:3], 3'b000};
        last_byte = {{(ADDR_W-IDX_W-3){1'b0}}, sel_q[SEL_W-1:3], 3'b111};
        eff_pl    = (cpl_q > sel_q[1:0]) ? cpl_q : sel_q[1:0];
        if (!dec.usr)              vcode = LF_SYSTEM;
        else if (!dec.present)     vcode = LF_ABSENT;
        else if (eff_pl > dec.dpl) vcode = LF_PRIV;
        else                       vcode = LF_NONE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (ld_valid) nxt = S_BOUND;
            S_BOUND:  nxt = (last_byte > tlim_q) ? S_DONE : S_FETCH;
            S_FETCH:  if (dr_valid) nxt = S_VERIFY;
            S_VERIFY: nxt = S_DONE;
            S_DONE:   nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // datapath captured along the walk
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_q   <= '0;
            sel_q   <= '0;
            cpl_q   <= '0;
            tbase_q <= '0;
            tlim_q  <= '0;
            desc_q  <= '0;
            fcode_q <= LF_NONE;
        end else begin
            if (state == S_IDLE && ld_valid) begin
                seg_q   <= ld_seg;
                sel_q   <= ld_sel;
                cpl_q   <= ld_cpl;
                tbase_q <= ld_sel[2] ? ldt_base  : gdt_base;
                tlim_q  <= ld_sel[2] ? ldt_limit : gdt_limit;
            end
            if (state == S_BOUND)
                fcode_q <= (last_byte > tlim_q) ? LF_BOUND : LF_NONE;
            if (state == S_FETCH && dr_valid)
                desc_q <= dr_data;
            if (state == S_VERIFY)
                fcode_q <= vcode;
        end
    end

    // outputs
    always_comb begin
        ld_busy  = (state != S_IDLE);
        dr_req   = (state == S_FETCH);
        dr_addr  = tbase_q + ent_off;
        ld_done  = (state == S_DONE);
        ld_fcode = (state == S_DONE) ? fcode_q : LF_NONE;
        ld_fault = (state == S_DONE) && (fcode_q != LF_NONE);
        wr_en    = (state == S_VERIFY) && (vcode == LF_NONE);
        wr_idx   = seg_q;
        wr_attr  = dec;
    end
endmodule

// File: rtl/seg_cache.sv
module seg_cache
    import seg_pkg::*;
#(
    parameter int NSEG  = 6,
    parameter int SEG_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEG_W-1:0] wr_idx,
    input  seg_attr_t        wr_attr,
    input  logic [SEG_W-1:0] rd_idx,
    output logic             rd_vld,
    output seg_attr_t        rd_attr
);
    seg_attr_t       ent [NSEG];
    logic [NSEG-1:0] vld;

    for (genvar i = 0; i < NSEG; i++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld[i] <= 1'b0;
                ent[i] <= '0;
            end else if (wr_en && wr_idx == SEG_W'(i)) begin
                vld[i] <= 1'b1;
                ent[i] <= wr_attr;
            end
        end
    end

    always_comb begin
        rd_vld  = 1'b0;
        rd_attr = '0;
        for (int i = 0; i < NSEG; i++) begin
            if ({1'b0, rd_idx} == (SEG_W+1)'(i)) begin
                rd_vld  = vld[i];
                rd_attr = ent[i];
            end
        end
    end
endmodule

// File: rtl/seg_access_unit.sv
module seg_access_unit
    import seg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ac_valid,
    input  logic [ADDR_W-1:0] ac_off,
    input  logic              ac_write,
    input  logic              slot_vld,
    input  seg_attr_t         slot,
    output logic              ac_rsp_valid,
    output logic [ADDR_W-1:0] ac_lin,
    output logic              ac_fault,
    output logic              ac_def32
);
    logic is_code, rw_ok, perm_bad, range_bad;

    always_comb begin
        is_code   = slot.typ[3];
        rw_ok     = slot.typ[1];
        perm_bad  = ac_write ? (is_code || !rw_ok) : (is_code && !rw_ok);
        range_bad = ac_off > slot.lim;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ac_rsp_valid <= 1'b0;
            ac_lin       <= '0;
            ac_fault     <= 1'b0;
            ac_def32     <= 1'b0;
        end else begin
            ac_rsp_valid <= ac_valid;
            if (ac_valid) begin
                ac_lin   <= slot.base + ac_off;
                ac_fault <= !slot_vld || range_bad || perm_bad;
                ac_def32 <= slot.def32;
            end
        end
    end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_pkg::*;
#(
    parameter  int NSEG  = 6,
    localparam int SEG_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [SEG_W-1:0]  ld_seg,
    input  logic [15:0]       ld_sel,
    input  logic [1:0]        ld_cpl,
    output logic              ld_busy,
    output logic              ld_done,
    output logic              ld_fault,
    output logic [2:0]        ld_fcode,
    input  logic [31:0]       gdt_base,
    input  logic [31:0]       gdt_limit,
    input  logic [31:0]       ldt_base,
    input  logic [31:0]       ldt_limit,
    output logic              dr_req,
    output logic [31:0]       dr_addr,
    input  logic              dr_valid,
    input  logic [63:0]       dr_data,
    input  logic              ac_valid,
    input  logic [SEG_W-1:0]  ac_seg,
    input  logic [31:0]       ac_off,
    input  logic              ac_write,
    output logic              ac_rsp_valid,
    output logic [31:0]       ac_lin,
    output logic              ac_fault,
    output logic              ac_def32
);
    logic             wr_en;
    logic [SEG_W-1:0] wr_idx;
    seg_attr_t        wr_attr;
    logic             slot_vld;
    seg_attr_t        slot;

    seg_load_fsm #(.NSEG(NSEG), .SEG_W(SEG_W)) u_load (
        .clk(clk), .rst_n(rst_n),
        .ld_valid(ld_valid), .ld_seg(ld_seg), .ld_sel(ld_sel), .ld_cpl(ld_cpl),
        .gdt_base(gdt_base), .gdt_limit(gdt_limit),
        .ldt_base(ldt_base), .ldt_limit(ldt_limit),
        .dr_valid(dr_valid), .dr_data(dr_data),
        .ld_busy(ld_busy), .ld_done(ld_done), .ld_fault(ld_fault), .ld_fcode(ld_fcode),
        .dr_req(dr_req), .dr_addr(dr_addr),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_attr(wr_attr)
    );

    seg_cache #(.NSEG(NSEG), .SEG_W(SEG_W)) u_cache (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_attr(wr_attr),
        .rd_idx(ac_seg), .rd_vld(slot_vld), .rd_attr(slot)
    );

    seg_access_unit u_acc (
        .clk(clk), .rst_n(rst_n),
        .ac_valid(ac_valid), .ac_off(ac_off), .ac_write(ac_write),
        .slot_vld(slot_vld), .slot(slot),
        .ac_rsp_valid(ac_rsp_valid), .ac_lin(ac_lin),
        .ac_fault(ac_fault), .ac_def32(ac_def32)
    );
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ld_valid,
    input logic        ld_busy,
    input logic        ld_done,
    input logic        ld_fault,
    input logic [2:0]  ld_fcode,
    input logic        dr_req,
    input logic        dr_valid,
    input logic [31:0] dr_addr,
    input logic        ac_valid,
    input logic        ac_rsp_valid
);
    p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
        ld_done |=> !ld_done);

    p_accept_busy_r13: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid && !ld_busy |=> ld_busy);

    p_idle_noreq_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_busy |-> !dr_req);

    p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dr_req && !dr_valid |=> dr_req && $stable(dr_addr));

    p_fault_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_done |-> (ld_fault == (ld_fcode != 3'd0)));

    p_code_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_done |-> ld_fcode <= 3'd4);

    p_rsp_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ac_valid |=> ac_rsp_valid);

    p_rsp_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ac_valid |=> !ac_rsp_valid);
endmodule

bind seg_xlate seg_xlate_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_busy(ld_busy),
    .ld_done(ld_done), .ld_fault(ld_fault), .ld_fcode(ld_fcode),
    .dr_req(dr_req), .dr_valid(dr_valid), .dr_addr(dr_addr),
    .ac_valid(ac_valid), .ac_rsp_valid(ac_rsp_valid)
);

// File: tb/seg_xlate_tb.sv
`timescale 1ns/1ps
module seg_xlate_tb_top;
    localparam int NSEG  = 6;
    localparam int SEG_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ld_valid = 1'b0;
    logic [SEG_W-1:0] ld_seg = '0;
    logic [15:0] ld_sel = '0;
    logic [1:0]  ld_cpl = '0;
    logic ld_busy, ld_done, ld_fault;
    logic [2:0] ld_fcode;
    logic [31:0] gdt_base = 32'h0001_0000, gdt_limit = 32'h0000_00FF;
    logic [31:0] ldt_base = 32'h0020_0000, ldt_limit = 32'h0000_003F;
    logic dr_req;
    logic [31:0] dr_addr;
    logic dr_valid = 1'b0;
    logic [63:0] dr_data = '0;
    logic ac_valid = 1'b0;
    logic [SEG_W-1:0] ac_seg = '0;
    logic [31:0] ac_off = '0;
    logic ac_write = 1'b0;
    logic ac_rsp_valid, ac_fault, ac_def32;
    logic [31:0] ac_lin;

    int n_chk = 0, n_bad = 0, rd_count = 0;
    logic [31:0] rd_addr_seen = '0;
    logic [63:0] resp_desc = '0;
    logic got_fault;
    logic [2:0] got_code;

    always #5 clk = ~clk;

    seg_xlate #(.NSEG(NSEG)) dut_i (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_desc(input logic [31:0] b, input logic [19:0] l,
        input bit g, input bit d32, input bit p, input logic [1:0] dpl, input bit s, input logic [3:0] t);
        logic [63:0] x;
        x = '0;
        x[15:0] = l[15:0];   x[31:16] = b[15:0];  x[39:32] = b[23:16];
        x[43:40] = t;        x[44] = s;           x[46:45] = dpl;  x[47] = p;
        x[51:48] = l[19:16]; x[54] = d32;         x[55] = g;       x[63:56] = b[31:24];
        return x;
    endfunction

    // descriptor memory responder: two idle cycles, then one data beat
    initial begin
        forever begin
            @(negedge clk);
            if (dr_req && !dr_valid) begin
                rd_count++;
                rd_addr_seen = dr_addr;
                @(negedge clk); @(negedge clk);
                dr_data = resp_desc; dr_valid = 1'b1;
                @(negedge clk);
                dr_valid = 1'b0;
            end
        end
    end

    task automatic do_load(input int seg, input logic [15:0] sel, input logic [1:0] cpl);
        @(negedge clk);
        ld_valid = 1'b1; ld_seg = SEG_W'(seg); ld_sel = sel; ld_cpl = cpl;
        @(negedge clk);
        ld_valid = 1'b0;
        for (int i = 0; i < 40 && !ld_done; i++) @(negedge clk);
        check(ld_done, "R13 load completes", {31'b0, ld_done}, 32'd1);
        got_fault = ld_fault; got_code = ld_fcode;
        @(negedge clk);
        check(!ld_done, "R13 done is one cycle", {31'b0, ld_done}, 32'd0);
    endtask

    task automatic do_acc(input int seg, input logic [31:0] off, input bit wr,
                          input bit exp_fault, input logic [31:0] exp_lin, input string req);
        @(negedge clk);
        ac_valid = 1'b1; ac_seg = SEG_W'(seg); ac_off = off; ac_write = wr;
        @(negedge clk);
        ac_valid = 1'b0;
        check(ac_rsp_valid, {req, " rsp valid"}, {31'b0, ac_rsp_valid}, 32'd1);
        check(ac_fault == exp_fault, {req, " fault"}, {31'b0, ac_fault}, {31'b0, exp_fault});
        if (!exp_fault)
            check(ac_lin == exp_lin, {req, " linear"}, ac_lin, exp_lin);
    endtask

    task automatic t_reset();
        check(!ld_busy && !ld_done && !dr_req && !ac_rsp_valid, "R13 reset state",
              {28'b0, ld_busy, ld_done, dr_req, ac_rsp_valid}, 32'd0);
    endtask

    task automatic t_gdt_load();
        int c0;
        resp_desc = mk_desc(32'h1234_5678, 20'h00FFF, 0, 1, 1, 2'd0, 1, 4'b0010);
        c0 = rd_count;
        do_load(0, 16'h0018, 2'd0);
        check(!got_fault && got_code == 0, "R8 good load", {29'b0, got_code}, 32'd0);
        check(rd_addr_seen == 32'h0001_0018, "R1 global address", rd_addr_seen, 32'h0001_0018);
        check(rd_count == c0 + 1, "R1 one read", rd_count, c0 + 1);
        do_acc(0, 32'h100, 0, 0, 32'h1234_5778, "R3 R9 base plus offset");
        check(ac_def32 == 1'b1, "R14 def32 set", {31'b0, ac_def32}, 32'd1);
        do_acc(0, 32'hFFF, 1, 0, 32'h1234_6677, "R10 offset at limit, data write");
        do_acc(0, 32'h1000, 0, 1, 0, "R10 offset past limit");
    endtask

    task automatic t_ldt_gran();
        resp_desc = mk_desc(32'h0000_0000, 20'h00001, 1, 0, 1, 2'd3, 1, 4'b0000);
        do_load(1, 16'h0017, 2'd3);
        check(!got_fault, "R7 equal privilege ok", {29'b0, got_code}, 32'd0);
        check(rd_addr_seen == 32'h0020_0010, "R1 local address", rd_addr_seen, 32'h0020_0010);
        do_acc(1, 32'h1FFF, 0, 0, 32'h1FFF, "R4 scaled limit last byte");
        check(ac_def32 == 1'b0, "R14 def32 clear", {31'b0, ac_def32}, 32'd0);
        do_acc(1, 32'h2000, 0, 1, 0, "R4 scaled limit plus one");
        do_acc(1, 32'h10, 1, 1, 0, "R11 write to read-only data");
    endtask

    task automatic t_bound();
        int c0;
        c0 = rd_count;
        do_load(2, 16'h0044, 2'd0);
        check(got_fault && got_code == 3'd1, "R2 entry past local limit", {29'b0, got_code}, 32'd1);
        check(rd_count == c0, "R2 no read issued", rd_count, c0);
        do_acc(2, 32'h0, 0, 1, 0, "R12 slot still empty");
        resp_desc = mk_desc(32'h0000_4000, 20'h000FF, 0, 1, 1, 2'd0, 1, 4'b0010);
        do_load(2, 16'h003C, 2'd0);
        check(!got_fault, "R2 entry ending on limit", {29'b0, got_code}, 32'd0);
        check(rd_count == c0 + 1, "R2 read issued", rd_count, c0 + 1);
    endtask

    task automatic t_refusals();
        resp_desc = mk_desc(32'h0, 20'hFF, 0, 1, 0, 2'd0, 0, 4'b1001);
        do_load(3, 16'h0008, 2'd0);
        check(got_code == 3'd2, "R5 R8 system beats absent", {29'b0, got_code}, 32'd2);
        resp_desc = mk_desc(32'h0, 20'hFF, 0, 1, 0, 2'd0, 1, 4'b0010);
        do_load(3, 16'h000B, 2'd0);
        check(got_code == 3'd3, "R6 R8 absent beats privilege", {29'b0, got_code}, 32'd3);
        resp_desc = mk_desc(32'h0, 20'hFF, 0, 1, 1, 2'd0, 1, 4'b0010);
        do_load(3, 16'h000B, 2'd0);
        check(got_code == 3'd4, "R7 requested level too high", {29'b0, got_code}, 32'd4);
        do_load(3, 16'h0008, 2'd3);
        check(got_code == 3'd4, "R7 current level too high", {29'b0, got_code}, 32'd4);
        do_acc(3, 32'h0, 0, 1, 0, "R12 refused slot stays empty");
        resp_desc = mk_desc(32'h0, 20'hFF, 0, 1, 1, 2'd0, 0, 4'b0010);
        do_load(2, 16'h0008, 2'd0);
        check(got_code == 3'd2, "R5 system segment refused", {29'b0, got_code}, 32'd2);
        do_acc(2, 32'h10, 0, 0, 32'h0000_4010, "R8 slot kept after refusal");
    endtask

    task automatic t_code();
        resp_desc = mk_desc(32'h8000_0000, 20'hFFFFF, 1, 1, 1, 2'd0, 1, 4'b1010);
        do_load(4, 16'h0010, 2'd0);
        check(!got_fault, "R11 code load", {29'b0, got_code}, 32'd0);
        do_acc(4, 32'h7FFF_FFFF, 0, 0, 32'hFFFF_FFFF, "R11 read readable code");
        do_acc(4, 32'h9000_0000, 0, 0, 32'h1000_0000, "R9 address wraps");
        do_acc(4, 32'h0, 1, 1, 0, "R11 write to code");
        resp_desc = mk_desc(32'h8000_0000, 20'hFFFFF, 1, 1, 1, 2'd0, 1, 4'b1000);
        do_load(4, 16'h0010, 2'd0);
        do_acc(4, 32'h0, 0, 1, 0, "R11 read of execute-only code");
    endtask

    task automatic t_busy_ignore();
        int c0;
        c0 = rd_count;
        resp_desc = mk_desc(32'h0000_7000, 20'hFF, 0, 1, 1, 2'd0, 1, 4'b0010);
        @(negedge clk);
        ld_valid = 1'b1; ld_seg = 3'd1; ld_sel = 16'h0020; ld_cpl = 2'd0;
        @(negedge clk);
        ld_valid = 1'b1; ld_seg = 3'd5; ld_sel = 16'h0028;
        check(ld_busy, "R13 busy after accept", {31'b0, ld_busy}, 32'd1);
        @(negedge clk);
        ld_valid = 1'b0;
        for (int i = 0; i < 40 && !ld_done; i++) @(negedge clk);
        check(rd_addr_seen == 32'h0001_0020, "R13 first selector kept", rd_addr_seen, 32'h0001_0020);
        repeat (8) @(negedge clk);
        check(rd_count == c0 + 1, "R13 second request ignored", rd_count, c0 + 1);
        do_acc(5, 32'h0, 0, 1, 0, "R13 R12 ignored slot unloaded");
        do_acc(1, 32'h5, 0, 0, 32'h0000_7005, "R13 first slot loaded");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_gdt_load();
        t_ldt_gran();
        t_bound();
        t_refusals();
        t_code();
        t_busy_ignore();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule